// File: doc/BRIEF.md
# Lock-free set/clear pin bank

This block drives up to eight general-purpose pins from one 32-bit register. Software never reads, modifies and writes that word back. Each pin owns four write-one command bits: drive low, drive high, become an output and become an input. A write acts only on the bits that are 1, so two agents that touch different pins can write the same word concurrently without a lock, and neither undoes the other's change.

Each pin has an output level latch and a direction latch. The level latch always feeds the pad's data line, whatever the pin's direction. Software can therefore preload a level while the pin is still an input and then enable the driver without a glitch. Pad inputs cross into the clock domain through a two-flop synchroniser. A read strobe captures a word that carries each pin's synchronised level and its direction. The pin count is a parameter from 1 to 8. Command bits for pins that do not exist are ignored.

Top module: `atomic_pin_bank`

## Requirements
- R1: A write with bit 2n set and bit 2n+1 clear sets pin n's output level (`pin_out[n]`) to 0 on the following clock edge.
- R2: A write with bit 2n+1 set and bit 2n clear sets `pin_out[n]` to 1 on the following clock edge.
- R3: A write with bit 2n+16 set and bit 2n+17 clear makes pin n an output (`pin_oe[n]` = 1) on the following clock edge.
- R4: A write with bit 2n+17 set and bit 2n+16 clear makes pin n an input (`pin_oe[n]` = 0) on the following clock edge.
- R5: Bits written as 0 leave every latch unchanged, so a write aimed at one pin never alters another pin.
- R6: If bits 2n and 2n+1 are both 1 in one write, pin n's level latch is unchanged. If bits 2n+16 and 2n+17 are both 1, its direction latch is unchanged.
- R7: The level latch can be written while the pin is an input, and `pin_out` shows it. Switching the pin to output then leaves `pin_out` unchanged.
- R8: On a clock edge with `rd_en` high, `rd_data` bit 2n+1 is loaded with `pin_in[n]` as delayed by two synchroniser flops. A change of `pin_in` first appears on the third read edge after it. With `rd_en` low, `rd_data` holds its value.
- R9: Read bit 2n+16 returns pin n's direction (1 = output). All other bits read 0: even-numbered bits below 16, odd-numbered bits from 17 up, and bits of absent pins.
- R10: While reset is asserted, every pin is an input (`pin_oe` = 0), every level latch is 0 and `rd_data` is 0.
- R11: With fewer than eight pins, command bits that belong to absent pins have no effect on the pins that exist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe; `wr_data` is decoded on this edge |
| wr_data | input | 32 | Write-one command word |
| rd_en | input | 1 | Read strobe; `rd_data` is loaded on this edge |
| rd_data | output | 32 | Captured readback word |
| pin_out | output | PIN_COUNT | Output level latch for each pin |
| pin_oe | output | PIN_COUNT | Driver enable for each pin (1 = output) |
| pin_in | input | PIN_COUNT | Asynchronous pad level for each pin |

## Verification
The bench builds two copies of the block. The first has `PIN_COUNT` = 8: every command field in the word is live, so the table can hit all eight pins with one write and exercise the conflicting-bit rule at the top and bottom of the word. The second has `PIN_COUNT` = 4. Command bits for pins 4 to 7 then become absent-pin bits, which exposes any decode that does not stop at the parameter, and the readback's upper data and direction bits must stay 0.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned MAX_PINS = 8;
   localparam int unsigned DIR_BASE = 16;

   typedef struct packed {
      logic lvl_lo;
      logic lvl_hi;
      logic dir_out;
      logic dir_in;
   } pin_cmd_t;
endpackage

// File: rtl/setclr_decode.sv
module setclr_decode
   import pin_bank_pkg::*;
#(
   parameter int unsigned PIN_COUNT = 8
) (
   input  logic                            wr_en,
   input  logic [WORD_W-1:0]               wr_data,
   output pin_cmd_t [PIN_COUNT-1:0]        cmds
);
   logic unused_word_bits;
   assign unused_word_bits = ^wr_data;

   for (genvar n = 0; n < PIN_COUNT; n++) begin : g_pin
      localparam int unsigned LVL_BIT = 2 * n;
      localparam int unsigned DIR_BIT = DIR_BASE + 2 * n;
      assign cmds[n].lvl_lo  = wr_en & wr_data[LVL_BIT];
      assign cmds[n].lvl_hi  = wr_en & wr_data[LVL_BIT + 1];
      assign cmds[n].dir_out = wr_en & wr_data[DIR_BIT];
      assign cmds[n].dir_in  = wr_en & wr_data[DIR_BIT + 1];
   end
endmodule

// File: rtl/pin_cell.sv
module pin_cell
   import pin_bank_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  pin_cmd_t cmd,
   input  logic     pad_in,
   output logic     lvl_q,
   output logic     dir_q,
   output logic     in_sync
);
   logic lvl_change, dir_change;
   logic [SYNC_STAGES-1:0] sync_chain;

   // a command pair acts only when exactly one of its two bits is set
   assign lvl_change = cmd.lvl_lo ^ cmd.lvl_hi;
   assign dir_change = cmd.dir_out ^ cmd.dir_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         dir_q <= 1'b0;
      end else begin
         if (lvl_change) lvl_q <= cmd.lvl_hi;
         if (dir_change) dir_q <= cmd.dir_out;
      end
   end

   if (SYNC_STAGES == 2) begin : g_sync2
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_chain <= '0;
         else        sync_chain <= {sync_chain[0], pad_in};
      end
   end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_chain <= '0;
         else        sync_chain <= {sync_chain[SYNC_STAGES-2:0], pad_in};
      end
   end
   assign in_sync = sync_chain[SYNC_STAGES-1];

   // R1
   lvl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.lvl_lo && !cmd.lvl_hi) |=> !lvl_q);
   // R2
   lvl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.lvl_hi && !cmd.lvl_lo) |=> lvl_q);
   // R3
   dir_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.dir_out && !cmd.dir_in) |=> dir_q);
   // R4
   dir_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.dir_in && !cmd.dir_out) |=> !dir_q);
   // R6
   lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.lvl_lo == cmd.lvl_hi) |=> $stable(lvl_q));
   // R6
   dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.dir_out == cmd.dir_in) |=> $stable(dir_q));
endmodule

// File: rtl/readback_capture.sv
module readback_capture
   import pin_bank_pkg::*;
#(
   parameter int unsigned PIN_COUNT = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rd_en,
   input  logic [PIN_COUNT-1:0] lvl_in,
   input  logic [PIN_COUNT-1:0] dir_in,
   output logic [WORD_W-1:0]    rd_word
);
   localparam logic [WORD_W-1:0] LIVE_MASK = live_mask();

   function automatic logic [WORD_W-1:0] live_mask();
      logic [WORD_W-1:0] m;
      m = '0;
      for (int n = 0; n < int'(PIN_COUNT); n++) begin
         m[2*n + 1]        = 1'b1;
         m[DIR_BASE + 2*n] = 1'b1;
      end
      return m;
   endfunction

   logic [WORD_W-1:0] word_d;

   always_comb begin
      word_d = '0;
      for (int n = 0; n < int'(PIN_COUNT); n++) begin
         word_d[2*n + 1]        = lvl_in[n];
         word_d[DIR_BASE + 2*n] = dir_in[n];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_word <= '0;
      else if (rd_en) rd_word <= word_d;
   end

   // R8
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_word));
   // R9
   rd_idle_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_word & ~LIVE_MASK) == '0);
endmodule

// File: rtl/atomic_pin_bank.sv
module atomic_pin_bank
   import pin_bank_pkg::*;
#(
   parameter int unsigned PIN_COUNT   = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [31:0]          wr_data,
   input  logic                 rd_en,
   output logic [31:0]          rd_data,
   output logic [PIN_COUNT-1:0] pin_out,
   output logic [PIN_COUNT-1:0] pin_oe,
   input  logic [PIN_COUNT-1:0] pin_in
);
   if (PIN_COUNT < 1 || PIN_COUNT > MAX_PINS) begin : g_bad_pins
      $error("PIN_COUNT must lie in 1..8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   pin_cmd_t [PIN_COUNT-1:0] cmds;
   logic     [PIN_COUNT-1:0] in_sync;

   setclr_decode #(.PIN_COUNT(PIN_COUNT)) u_decode (
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .cmds    (cmds)
   );

   for (genvar n = 0; n < PIN_COUNT; n++) begin : g_cell
      pin_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .cmd     (cmds[n]),
         .pad_in  (pin_in[n]),
         .lvl_q   (pin_out[n]),
         .dir_q   (pin_oe[n]),
         .in_sync (in_sync[n])
      );
   end

   readback_capture #(.PIN_COUNT(PIN_COUNT)) u_readback (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .lvl_in  (in_sync),
      .dir_in  (pin_oe),
      .rd_word (rd_data)
   );

   // R5
   no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || wr_data == '0) |=> ($stable(pin_out) && $stable(pin_oe)));
   // R10
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |-> (pin_oe == '0 && pin_out == '0 && rd_data == '0));
endmodule

// File: tb/test_atomic_pin_bank.sv
module test_atomic_pin_bank;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   // 8-pin instance
   logic        w8 = 1'b0, r8 = 1'b0;
   logic [31:0] d8 = '0, q8;
   logic [7:0]  o8, e8, i8 = '0;
   // 4-pin instance
   logic        w4 = 1'b0, r4 = 1'b0;
   logic [31:0] d4 = '0, q4;
   logic [3:0]  o4, e4, i4 = '0;

   atomic_pin_bank #(.PIN_COUNT(8)) i_atomic_pin_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(w8), .wr_data(d8), .rd_en(r8),
      .rd_data(q8), .pin_out(o8), .pin_oe(e8), .pin_in(i8));

   atomic_pin_bank #(.PIN_COUNT(4)) i_atomic_pin_bank_4 (
      .clk(clk), .rst_n(rst_n), .wr_en(w4), .wr_data(d4), .rd_en(r4),
      .rd_data(q4), .pin_out(o4), .pin_oe(e4), .pin_in(i4));

   int total = 0, bad = 0;
   bit done = 1'b0;

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // readback layout from R8/R9: level at 2n+1, direction at 2n+16
   function automatic logic [31:0] rb(logic [7:0] dir, logic [7:0] lvl, int pins);
      logic [31:0] r = '0;
      for (int n = 0; n < pins; n++) begin
         r[2*n+1]  = lvl[n];
         r[16+2*n] = dir[n];
      end
      return r;
   endfunction

   // {command word, expected level latches, expected directions}
   localparam logic [47:0] VEC [13] = '{
      {32'h0000_0002, 8'h01, 8'h00},   // R2 pin0 high
      {32'h0001_0000, 8'h01, 8'h01},   // R3 pin0 output
      {32'h0000_AAAA, 8'hFF, 8'h01},   // R2 all high
      {32'h5555_0000, 8'hFF, 8'hFF},   // R3 all outputs
      {32'h0000_0001, 8'hFE, 8'hFF},   // R1 pin0 low
      {32'h0000_0003, 8'hFE, 8'hFF},   // R6 level conflict
      {32'h0003_0000, 8'hFE, 8'hFF},   // R6 direction conflict
      {32'hAAAA_0000, 8'hFE, 8'h00},   // R4 all inputs
      {32'h0000_5555, 8'h00, 8'h00},   // R1 all low
      {32'h0000_0000, 8'h00, 8'h00},   // R5 empty write
      {32'h0000_8004, 8'h80, 8'h00},   // R5 pin7 high, pin1 low
      {32'h0010_0020, 8'h84, 8'h04},   // R5 pin2 high and output
      {32'h0000_0006, 8'h85, 8'h04}    // R5 pin0 high, pin1 low
   };

   task automatic wr8(logic [31:0] d);
      @(negedge clk); w8 = 1'b1; d8 = d;
      @(negedge clk); w8 = 1'b0; d8 = '0;
   endtask

   task automatic rd8();
      @(negedge clk); r8 = 1'b1;
      @(negedge clk); r8 = 1'b0;
   endtask

   task automatic wr4(logic [31:0] d);
      @(negedge clk); w4 = 1'b1; d4 = d;
      @(negedge clk); w4 = 1'b0; d4 = '0;
   endtask

   initial begin
      logic [31:0] held;
      repeat (3) @(negedge clk);
      check("R10 oe", {24'h0, e8}, 32'h0);
      check("R10 out", {24'h0, o8}, 32'h0);
      check("R10 rd", q8, 32'h0);
      check("R10 oe4", {28'h0, e4}, 32'h0);
      rst_n = 1'b1;

      for (int v = 0; v < 13; v++) begin
         wr8(VEC[v][47:16]);
         check("R1/R2/R5/R6 out", {24'h0, o8}, {24'h0, VEC[v][15:8]});
         check("R3/R4/R5/R6 oe", {24'h0, e8}, {24'h0, VEC[v][7:0]});
         rd8();
         check("R9 readback", q8, rb(VEC[v][7:0], 8'h00, 8));
      end

      // R7: preload pin3 high while input, then enable
      wr8(32'h0000_0080);
      check("R7 preload out", {31'h0, o8[3]}, 32'h1);
      check("R7 still input", {31'h0, e8[3]}, 32'h0);
      wr8(32'h0040_0000);
      check("R7 enabled", {24'h0, e8}, 32'h0000_000C);
      check("R7 level kept", {24'h0, o8}, 32'h0000_008D);

      // R8 synchroniser latency
      @(negedge clk); i8 = 8'hA5; r8 = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R8 not yet", q8, rb(8'h0C, 8'h00, 8));
      @(negedge clk);
      check("R8 synced", q8, rb(8'h0C, 8'hA5, 8));
      r8 = 1'b0;

      // R8 hold with rd_en low
      held = q8;
      i8 = 8'h5A;
      wr8(32'h0100_0000);
      repeat (3) @(negedge clk);
      check("R8 hold", q8, held);
      rd8();
      check("R8 refresh", q8, rb(8'h1C, 8'h5A, 8));

      // R11 4-pin instance
      wr4(32'hAAAA_AAAA);
      check("R11 out4", {28'h0, o4}, 32'hF);
      check("R11 oe4", {28'h0, e4}, 32'h0);
      wr4(32'h5555_0000);
      check("R11 oe4 set", {28'h0, e4}, 32'hF);
      wr4(32'h5500_5500);
      check("R11 absent low", {28'h0, o4}, 32'hF);
      check("R11 absent dir", {28'h0, e4}, 32'hF);
      i4 = 4'hF;
      repeat (3) @(negedge clk);
      @(negedge clk); r4 = 1'b1;
      @(negedge clk); r4 = 1'b0;
      check("R9/R11 rd4", q4, 32'h0055_00AA);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule